// File: doc/BRIEF.md
# Interrupt Mask and Acceptance Gate

This block owns the processor's maskable-interrupt enable bit and decides, each time an instruction finishes, whether a pending maskable request is taken. It sits between the instruction sequencer, which reports instruction boundaries and mask-changing instructions, and the exception sequencer, which stacks the registers and then fetches the first handler instruction.

Two ordering rules are enforced. First, an instruction that turns the mask from 1 to 0 opens a one-boundary window in which no request is recognised, so the instruction after it always runs. Second, once a request is taken, the mask is forced to 1 when the exception sequencer reports that stacking has finished, and only then is the first handler fetch allowed.

Top module: `irq_gate`

## Requirements
- R1: After reset, `mask_o` is 1 and both `take_o` and `fetch_ok_o` are 0.
- R2: `take_o` is a one-cycle pulse in the cycle after a clock edge at which `boundary_i` and `irq_req_i` are 1, `mask_o` is 0, no shadow is active and no earlier acceptance is still being handed off.
- R3: While `mask_o` is 1, no boundary produces `take_o`, whatever `irq_req_i` is.
- R4: A boundary with `clr_flag_i` = 1 is a shadow boundary, and takes nothing, when the mask held 1 right after the previous boundary (or since reset if there was none).
- R5: A boundary with `clr_flag_i` = 1 whose previous boundary left the mask at 0 is not a shadow and may take a request.
- R6: The shadow covers exactly one boundary; the next boundary takes a pending request when the mask is 0.
- R7: After `take_o`, the mask keeps its value until `stack_done_i`; at that edge the mask becomes 1 and `fetch_ok_o` becomes 1 on the same edge.
- R8: `fetch_ok_o` stays 1 until the next boundary edge, where it drops; from `take_o` until then no further request is taken.
- R9: `mask_set_i` forces the mask to 1 on the next edge, overriding `mask_clr_i` and an acceptance in the same cycle.
- R10: `mask_clr_i` alone clears the mask on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Strobe: an instruction has completed |
| irq_req_i | input | 1 | A maskable request is pending |
| mask_set_i | input | 1 | Instruction sets the mask |
| mask_clr_i | input | 1 | Instruction clears the mask |
| clr_flag_i | input | 1 | With `boundary_i`: the finished instruction cleared the mask |
| stack_done_i | input | 1 | Exception sequencer finished stacking |
| mask_o | output | 1 | Current interrupt mask (1 = blocked) |
| take_o | output | 1 | One-cycle pulse: request accepted |
| fetch_ok_o | output | 1 | First handler fetch may proceed |

## Verification
On every cycle the assertions check that an acceptance is preceded by a boundary with a pending request and a clear mask, that a shadow boundary never yields an acceptance, that the handler fetch is never allowed while the mask is 0, that a set command always leaves the mask at 1, and that acceptances never come back to back. Only the bench scenarios show that the shadow depends on the mask held at the previous boundary, that it is released after exactly one boundary, and that a second request is held off for the whole stacking and fetch hand-off.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_STACK = 2'd1,
    HS_FETCH = 2'd2
  } hs_state_t;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic mask_next_o,
  output logic mask_q_o
);
  // set has priority over clear
  always_comb begin
    if (set_i)      mask_next_o = 1'b1;
    else if (clr_i) mask_next_o = 1'b0;
    else            mask_next_o = mask_q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q_o <= RESET_VAL;
    else     mask_q_o <= mask_next_o;
  end
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic boundary_i,
  input  logic clr_flag_i,
  input  logic mask_next_i,
  output logic shadow_o
);
  // mask value as the current instruction began
  logic start_mask_q;

  always_ff @(posedge clk) begin
    if (rst)             start_mask_q <= RESET_VAL;
    else if (boundary_i) start_mask_q <= mask_next_i;
  end

  assign shadow_o = boundary_i & clr_flag_i & start_mask_q;
endmodule

// File: rtl/irq_handoff.sv
module irq_handoff
  import irq_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  input  logic boundary_i,
  input  logic stack_done_i,
  output logic busy_o,
  output logic auto_set_o,
  output logic take_o,
  output logic fetch_ok_o
);
  hs_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_IDLE:  if (accept_i)     state_d = HS_STACK;
      HS_STACK: if (stack_done_i) state_d = HS_FETCH;
      HS_FETCH: if (boundary_i)   state_d = HS_IDLE;
      default:                    state_d = HS_IDLE;
    endcase
  end

  assign busy_o     = (state_q != HS_IDLE);
  assign auto_set_o = (state_q == HS_STACK) & stack_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= HS_IDLE;
      take_o     <= 1'b0;
      fetch_ok_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      take_o     <= accept_i & (state_q == HS_IDLE);
      fetch_ok_o <= (state_d == HS_FETCH);
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter logic MASK_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic boundary_i,
  input  logic irq_req_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  input  logic clr_flag_i,
  input  logic stack_done_i,
  output logic mask_o,
  output logic take_o,
  output logic fetch_ok_o
);
  logic mask_next;
  logic shadow_act;
  logic busy;
  logic auto_set;
  logic accept;

  irq_mask_reg #(.RESET_VAL(MASK_RESET)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .set_i      (mask_set_i | auto_set),
    .clr_i      (mask_clr_i),
    .mask_next_o(mask_next),
    .mask_q_o   (mask_o)
  );

  irq_shadow #(.RESET_VAL(MASK_RESET)) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary_i),
    .clr_flag_i (clr_flag_i),
    .mask_next_i(mask_next),
    .shadow_o   (shadow_act)
  );

  assign accept = boundary_i & irq_req_i & ~mask_o & ~shadow_act & ~busy;

  irq_handoff u_handoff (
    .clk         (clk),
    .rst         (rst),
    .accept_i    (accept),
    .boundary_i  (boundary_i),
    .stack_done_i(stack_done_i),
    .busy_o      (busy),
    .auto_set_o  (auto_set),
    .take_o      (take_o),
    .fetch_ok_o  (fetch_ok_o)
  );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
  input logic clk,
  input logic rst,
  input logic boundary_i,
  input logic irq_req_i,
  input logic mask_set_i,
  input logic stack_done_i,
  input logic mask_o,
  input logic take_o,
  input logic fetch_ok_o,
  input logic shadow_act
);
  // R2
  take_cause_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(boundary_i && irq_req_i && !mask_o));

  // R4
  shadow_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(shadow_act) |-> !take_o);

  // R7
  fetch_masked_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_ok_o |-> mask_o);

  // R7
  fetch_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_ok_o) |-> $past(stack_done_i));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    mask_set_i |=> mask_o);

  // R8
  single_take_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
endmodule

bind irq_gate irq_gate_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .boundary_i  (boundary_i),
  .irq_req_i   (irq_req_i),
  .mask_set_i  (mask_set_i),
  .stack_done_i(stack_done_i),
  .mask_o      (mask_o),
  .take_o      (take_o),
  .fetch_ok_o  (fetch_ok_o),
  .shadow_act  (shadow_act)
);

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
  logic clk = 1'b0;
  logic rst, bnd, req, mset, mclr, cflag, sdone;
  logic mask_o, take_o, fetch_ok_o;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_gate u_dut (
    .clk(clk), .rst(rst), .boundary_i(bnd), .irq_req_i(req),
    .mask_set_i(mset), .mask_clr_i(mclr), .clr_flag_i(cflag),
    .stack_done_i(sdone), .mask_o(mask_o), .take_o(take_o),
    .fetch_ok_o(fetch_ok_o)
  );

  task automatic chk(input string req_id, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req_id, act, exp);
    end
  endtask

  task automatic idle();
    bnd = 0; req = 0; mset = 0; mclr = 0; cflag = 0; sdone = 0;
  endtask

  // apply the current inputs for one edge, then return them to idle
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // finish a pending handoff: stacking done, then one boundary
  task automatic finish_handoff();
    sdone = 1; tick();
    chk("R7 mask set at stack done", mask_o, 1'b1);
    chk("R7 fetch allowed", fetch_ok_o, 1'b1);
    bnd = 1; tick();
    chk("R8 fetch drops at boundary", fetch_ok_o, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk("R1 mask after reset", mask_o, 1'b1);
    chk("R1 take after reset", take_o, 1'b0);
    chk("R1 fetch after reset", fetch_ok_o, 1'b0);

    // R2 R3 sweep: mask state x request x clear flag, mask held steady
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++)
        for (int f = 0; f < 2; f++) begin
          do_reset();
          if (m == 0) begin
            mclr = 1; tick();
            bnd = 1; tick();         // previous boundary leaves mask 0
          end
          bnd = 1; req = r[0]; cflag = f[0]; tick();
          chk(m ? "R3 masked sweep" : "R2 unmasked sweep", take_o,
              logic'(r == 1 && m == 0));
          bnd = 1; tick();
          chk("R2 take is a pulse", take_o, 1'b0);
        end

    // R10 clear, R4 shadow, R6 release, R8 handoff
    do_reset();
    mclr = 1; tick();
    chk("R10 clear alone", mask_o, 1'b0);
    bnd = 1; req = 1; cflag = 1; tick();
    chk("R4 shadow blocks", take_o, 1'b0);
    bnd = 1; req = 1; tick();
    chk("R6 shadow released", take_o, 1'b1);
    chk("R7 mask unchanged before stack done", mask_o, 1'b0);
    bnd = 1; req = 1; tick();
    chk("R8 no take while stacking", take_o, 1'b0);
    req = 1; tick();
    chk("R7 mask still clear while stacking", mask_o, 1'b0);
    finish_handoff();

    // R5 flag without shadow when mask was already 0
    mclr = 1; tick();
    bnd = 1; tick();
    bnd = 1; req = 1; cflag = 1; tick();
    chk("R5 no shadow when mask was clear", take_o, 1'b1);
    finish_handoff();
    chk("R7 mask stays set after handoff", mask_o, 1'b1);

    // R9 set beats clear
    mclr = 1; tick();
    mset = 1; mclr = 1; tick();
    chk("R9 set over clear", mask_o, 1'b1);

    // R9 set in the same cycle as an acceptance
    mclr = 1; tick();
    bnd = 1; tick();
    bnd = 1; req = 1; mset = 1; tick();
    chk("R9 acceptance with set: take", take_o, 1'b1);
    chk("R9 acceptance with set: mask", mask_o, 1'b1);
    finish_handoff();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule